// File: doc/BRIEF.md
# Waveform Zero-Suppression and Rebinning Unit

This unit takes one digitized readout window per channel, framed by start and end markers, and turns it into a short record. It holds the window in a small local buffer. While the samples arrive it forms the baseline sum, finds the peak and watches the slope for pile-up. After the window closes, one scan over the buffer produces the baseline spread and the integral above baseline.

A channel whose peak does not rise far enough above the baseline noise produces only a header. A channel that passes the test produces its raw samples near the peak, followed by tail samples summed in groups of four or eight. In calibration mode the channel produces a single charge word instead of samples. The configuration inputs are held steady for the length of a window. A new window is accepted only while no record is being built. The output has no back-pressure.

Top module: `zsr_unit`

## Requirements
- R1: After reset, `out_valid` is low until a window has been received.
- R2: The baseline `m` is the floor of the sum of the first 16 samples divided by 16. The spread `d` is the sum of |s−m| over those 16 samples. With `a` = peak−m, the channel is hit exactly when 16·a > `cfg_nsig`·d.
- R3: A channel that is not hit produces one word: a header with bit 0 clear and `out_last` set.
- R4: The header is the first word of a record, marked by `out_head`. Bit 0 is hit, bit 1 is pile-up, bit 2 is calibration mode, bits 8:3 hold the index of the first sample with the window maximum, and bits 18:9 hold `a`.
- R5: For each sample after the first, d = s[i]−s[i−1] is counted as rising when d > `cfg_dead` and falling when d < −`cfg_dead`, and is otherwise ignored. The pile-up flag is set when the direction changes more than twice within the window.
- R6: In sample mode, a hit channel produces the raw samples from index max(peak−`cfg_pre`,0) through min(peak+`cfg_post`, len−1), in order.
- R7: The samples after that region are summed in groups of 4 (`cfg_ratio8`=0) or 8 (`cfg_ratio8`=1), one word per group. A final partial group is summed as it stands.
- R8: In calibration mode (`cfg_calib`=1), a hit channel produces one word after the header: the sum over the window of max(s−m,0).
- R9: `out_last` marks the final word of each record, and at least one idle cycle follows it.
- R10: A window holds 16 to 64 samples. Samples after the 64th are dropped from every computation and from the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_first | input | 1 | First sample of a window |
| in_last | input | 1 | Last sample of a window |
| in_sample | input | 10 | Unsigned sample value |
| cfg_nsig | input | 4 | Threshold multiple of the spread |
| cfg_dead | input | 10 | Dead band for slope direction |
| cfg_pre | input | 6 | Fine samples kept before the peak |
| cfg_post | input | 6 | Fine samples kept after the peak |
| cfg_ratio8 | input | 1 | Tail ratio: 0 for 4:1, 1 for 8:1 |
| cfg_calib | input | 1 | Emit the integral instead of samples |
| out_valid | output | 1 | Output word present |
| out_head | output | 1 | Word is a header |
| out_last | output | 1 | Final word of the record |
| out_data | output | 24 | Header, sample, tail sum or integral |

## Verification
Two events can land on the same output word: the end of the fine region can also be the end of the window. In that case the last raw sample carries `out_last` and no tail word follows. The bench provokes this with a peak near the end of a 64-sample window and a long post length. It also provokes a tail whose last group is cut short by the end of the window, so that the group sum and `out_last` land on the same word. In every window a reference model computes the expected word sequence, including the flag on each word, and every emitted word is compared against it in order.

// File: rtl/zsr_pkg.sv
package zsr_pkg;
  parameter int SW   = 10;
  parameter int MAXW = 64;
  parameter int NB   = 16;
  parameter int OW   = 24;
  parameter int NSW  = 4;
  localparam int IW    = $clog2(MAXW);
  localparam int CW    = IW + 1;
  localparam int NBL   = $clog2(NB);
  localparam int MADW  = SW + NBL + 1;
  localparam int INTW  = SW + CW;
  localparam int TAILW = SW + 4;
  localparam int PROD  = MADW + NSW;

  typedef enum logic [2:0] {E_IDLE, E_SCAN, E_HDR, E_FINE, E_TAIL, E_INTEG} est_t;

  function automatic logic [SW-1:0] above_base(logic [SW-1:0] s, logic [SW-1:0] m);
    return (s > m) ? (s - m) : '0;
  endfunction

  function automatic logic [SW-1:0] abs_gap(logic [SW-1:0] s, logic [SW-1:0] m);
    return (s > m) ? (s - m) : (m - s);
  endfunction

  function automatic logic over_noise(logic [SW-1:0] amp, logic [MADW-1:0] mad,
                                      logic [NSW-1:0] n);
    logic [PROD-1:0] lhs, rhs;
    lhs = PROD'(amp) << NBL;
    rhs = PROD'(n) * PROD'(mad);
    return lhs > rhs;
  endfunction
endpackage

// File: rtl/zsr_slope.sv
module zsr_slope
  import zsr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          v,
  input  logic          first,
  input  logic [SW-1:0] sample,
  input  logic [SW-1:0] dead,
  output logic          pile
);
  logic [SW-1:0] prev;
  logic [1:0]    lsgn;   // 0 none, 1 rising, 2 falling
  logic [1:0]    chg;
  logic signed [SW+1:0] diff, band;
  logic          rise, fall, turn;

  assign diff = $signed({2'b00, sample}) - $signed({2'b00, prev});
  assign band = $signed({2'b00, dead});
  assign rise = diff > band;
  assign fall = diff < -band;
  assign turn = (rise && lsgn == 2'd2) || (fall && lsgn == 2'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= '0; lsgn <= '0; chg <= '0;
    end else if (v) begin
      prev <= sample;
      if (first) begin
        lsgn <= '0; chg <= '0;
      end else begin
        if (rise) lsgn <= 2'd1;
        else if (fall) lsgn <= 2'd2;
        if (turn && chg != 2'd3) chg <= chg + 2'd1;
      end
    end
  end

  assign pile = (chg == 2'd3);

  // R5
  pileup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pile && !(v && first)) |=> pile);
endmodule

// File: rtl/zsr_capture.sv
module zsr_capture
  import zsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v,
  input  logic              first,
  input  logic              last,
  input  logic [SW-1:0]     sample,
  input  logic [IW-1:0]     rd_addr,
  output logic [SW-1:0]     rd_data,
  output logic [CW-1:0]     len,
  output logic [IW-1:0]     peak,
  output logic [SW-1:0]     pmax,
  output logic [SW+NBL-1:0] bsum,
  output logic              room,
  output logic              done
);
  logic [SW-1:0] mem [MAXW];
  logic          store;

  assign room    = len < CW'(MAXW);
  assign store   = v && (first || room);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (store) mem[first ? '0 : len[IW-1:0]] <= sample;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len <= '0; peak <= '0; pmax <= '0; bsum <= '0; done <= 1'b0;
    end else begin
      done <= v && last;
      if (store) begin
        if (first) begin
          len <= CW'(1); bsum <= (SW+NBL)'(sample); pmax <= sample; peak <= '0;
        end else begin
          len <= len + CW'(1);
          if (len < CW'(NB)) bsum <= bsum + (SW+NBL)'(sample);
          if (sample > pmax) begin
            pmax <= sample; peak <= len[IW-1:0];
          end
        end
      end
    end
  end

  // R10
  cap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len <= CW'(MAXW));
endmodule

// File: rtl/zsr_emit.sv
module zsr_emit
  import zsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     len,
  input  logic [IW-1:0]     peak,
  input  logic [SW-1:0]     pmax,
  input  logic [SW+NBL-1:0] bsum,
  input  logic              pile,
  input  logic [NSW-1:0]    cfg_nsig,
  input  logic [IW-1:0]     cfg_pre,
  input  logic [IW-1:0]     cfg_post,
  input  logic              cfg_ratio8,
  input  logic              cfg_calib,
  output logic [IW-1:0]     rd_addr,
  input  logic [SW-1:0]     rd_data,
  output logic              busy,
  output logic              out_valid,
  output logic              out_head,
  output logic              out_last,
  output logic [OW-1:0]     out_data
);
  est_t st;
  logic [CW-1:0]    idx, len_q, fstart, fend, lastix, reach;
  logic [IW-1:0]    peak_q;
  logic [SW-1:0]    max_q, mean_q, amp;
  logic             pile_q, hit;
  logic [MADW-1:0]  mad_q;
  logic [INTW-1:0]  integ_q;
  logic [TAILW-1:0] acc_q, acc_n;
  logic [3:0]       grp_q, grp_n, gsize;
  logic             fine_end, tail_emit, win_end;

  assign lastix   = len_q - CW'(1);
  assign amp      = max_q - mean_q;
  assign hit      = over_noise(amp, mad_q, cfg_nsig);
  assign fstart   = (peak_q >= cfg_pre) ? CW'(peak_q - cfg_pre) : '0;
  assign reach    = CW'(peak_q) + CW'(cfg_post);
  assign fend     = (reach > lastix) ? lastix : reach;
  assign win_end  = idx == lastix;
  assign fine_end = (st == E_FINE) && (idx == fend);
  assign gsize    = cfg_ratio8 ? 4'd8 : 4'd4;
  assign grp_n    = grp_q + 4'd1;
  assign acc_n    = acc_q + TAILW'(rd_data);
  assign tail_emit = (st == E_TAIL) && (grp_n == gsize || win_end);
  assign rd_addr  = idx[IW-1:0];
  assign busy     = st != E_IDLE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= E_IDLE; idx <= '0; len_q <= '0; peak_q <= '0; max_q <= '0;
      mean_q <= '0; pile_q <= 1'b0; mad_q <= '0; integ_q <= '0;
      acc_q <= '0; grp_q <= '0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          st <= E_SCAN; idx <= '0; len_q <= len; peak_q <= peak; max_q <= pmax;
          mean_q <= SW'(bsum >> NBL); pile_q <= pile; mad_q <= '0; integ_q <= '0;
        end
        E_SCAN: begin
          if (idx < CW'(NB)) mad_q <= mad_q + MADW'(abs_gap(rd_data, mean_q));
          integ_q <= integ_q + INTW'(above_base(rd_data, mean_q));
          idx <= idx + CW'(1);
          if (win_end) st <= E_HDR;
        end
        E_HDR: begin
          idx <= fstart;
          if (!hit) st <= E_IDLE;
          else if (cfg_calib) st <= E_INTEG;
          else st <= E_FINE;
        end
        E_INTEG: st <= E_IDLE;
        E_FINE: begin
          idx <= idx + CW'(1);
          grp_q <= '0; acc_q <= '0;
          if (fine_end) st <= win_end ? E_IDLE : E_TAIL;
        end
        E_TAIL: begin
          idx <= idx + CW'(1);
          if (tail_emit) begin
            acc_q <= '0; grp_q <= '0;
            if (win_end) st <= E_IDLE;
          end else begin
            acc_q <= acc_n; grp_q <= grp_n;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid = 1'b0; out_head = 1'b0; out_last = 1'b0; out_data = '0;
    case (st)
      E_HDR: begin
        out_valid = 1'b1; out_head = 1'b1; out_last = !hit;
        out_data = OW'({amp, peak_q, cfg_calib, pile_q, hit});
      end
      E_INTEG: begin out_valid = 1'b1; out_last = 1'b1; out_data = OW'(integ_q); end
      E_FINE: begin
        out_valid = 1'b1; out_last = fine_end && win_end; out_data = OW'(rd_data);
      end
      E_TAIL: begin
        out_valid = tail_emit; out_last = tail_emit && win_end; out_data = OW'(acc_n);
      end
      default: ;
    endcase
  end

  // R3
  miss_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_head && !out_data[0]) |-> out_last);
  // R8
  calib_one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_head && out_data[0] && out_data[2]) |=>
      (out_valid && out_last && !out_head));
  // R9
  gap_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |=> !out_valid);
  // R6
  fine_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_FINE) |-> (idx < len_q));
  // R4
  head_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_head |-> $past(st) == E_SCAN);
endmodule

// File: rtl/zsr_unit.sv
module zsr_unit
  import zsr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_first,
  input  logic           in_last,
  input  logic [9:0]     in_sample,
  input  logic [3:0]     cfg_nsig,
  input  logic [9:0]     cfg_dead,
  input  logic [5:0]     cfg_pre,
  input  logic [5:0]     cfg_post,
  input  logic           cfg_ratio8,
  input  logic           cfg_calib,
  output logic           out_valid,
  output logic           out_head,
  output logic           out_last,
  output logic [23:0]    out_data
);
  logic              busy, done, room, acc_v;
  logic [IW-1:0]     rd_addr, peak;
  logic [SW-1:0]     rd_data, pmax;
  logic [CW-1:0]     len;
  logic [SW+NBL-1:0] bsum;
  logic              pile;

  assign acc_v = in_valid && !busy && !done;

  zsr_capture u_cap (
    .clk, .rst_n, .v(acc_v), .first(in_first), .last(in_last), .sample(in_sample),
    .rd_addr, .rd_data, .len, .peak, .pmax, .bsum, .room, .done);

  zsr_slope u_slope (
    .clk, .rst_n, .v(acc_v && (in_first || room)), .first(in_first),
    .sample(in_sample), .dead(cfg_dead), .pile);

  zsr_emit u_emit (
    .clk, .rst_n, .start(done), .len, .peak, .pmax, .bsum, .pile,
    .cfg_nsig, .cfg_pre, .cfg_post, .cfg_ratio8, .cfg_calib,
    .rd_addr, .rd_data, .busy, .out_valid, .out_head, .out_last, .out_data);
endmodule

// File: tb/zsr_unit_bench.sv
module zsr_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_first = 0, in_last = 0;
  logic [9:0] in_sample = '0;
  logic [3:0] cfg_nsig = 4'd4;
  logic [9:0] cfg_dead = '0;
  logic [5:0] cfg_pre = '0, cfg_post = '0;
  logic cfg_ratio8 = 0, cfg_calib = 0;
  logic out_valid, out_head, out_last;
  logic [23:0] out_data;

  always #2.5 clk = ~clk;

  zsr_unit u_zsr_unit (.*);

  int vectors = 0, fails = 0, cycles = 0;
  logic [25:0] expq[$];
  string tagq[$];
  int smp[80];

  function automatic void push(int data, bit head, bit last, string tag);
    expq.push_back({head, last, data[23:0]});
    tagq.push_back(tag);
  endfunction

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      vectors++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected word: actual %h expected none", out_data);
      end else begin
        automatic logic [25:0] e = expq.pop_front();
        automatic string t = tagq.pop_front();
        if ({out_head, out_last, out_data} !== e) begin
          fails++;
          $display("FAIL %s actual h=%0b l=%0b %h expected h=%0b l=%0b %h",
                   t, out_head, out_last, out_data, e[25], e[24], e[23:0]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // base + small ripple + up to two triangular pulses
  task automatic make_wave(int n, int base, int ripple, int p1, int a1, int p2, int a2);
    for (int i = 0; i < n; i++) begin
      automatic int v = base + (ripple ? (i * 5) % 3 : 0);
      automatic int d1 = (i > p1) ? i - p1 : p1 - i;
      automatic int d2 = (i > p2) ? i - p2 : p2 - i;
      if (a1 - d1 * a1 / 4 > 0) v += a1 - d1 * a1 / 4;
      if (a2 - d2 * a2 / 4 > 0) v += a2 - d2 * a2 / 4;
      smp[i] = v;
    end
  endtask

  task automatic run_window(int ndrive, int nsig, int dead, int pre, int post,
                            bit r8, bit cal);
    int n, sum, mean, mad, mx, pk, amp, integ, chg, lsg, d, fs, fe, g, acc, cnt;
    bit hit, pile;
    n = (ndrive > 64) ? 64 : ndrive;
    sum = 0; for (int i = 0; i < 16; i++) sum += smp[i];
    mean = sum / 16;
    mad = 0; for (int i = 0; i < 16; i++) mad += (smp[i] > mean) ? smp[i] - mean : mean - smp[i];
    mx = smp[0]; pk = 0; integ = 0; chg = 0; lsg = 0;
    for (int i = 0; i < n; i++) begin
      if (smp[i] > mx) begin mx = smp[i]; pk = i; end
      if (smp[i] > mean) integ += smp[i] - mean;
      if (i > 0) begin
        d = smp[i] - smp[i-1];
        if (d > dead) begin if (lsg == -1) chg++; lsg = 1; end
        else if (d < -dead) begin if (lsg == 1) chg++; lsg = -1; end
      end
    end
    amp = mx - mean;
    hit = amp * 16 > nsig * mad;
    pile = chg > 2;
    push(hit | (pile << 1) | (cal << 2) | (pk << 3) | (amp << 9), 1, !hit,
         hit ? "R4 header" : "R3 R2 suppressed header");
    if (hit && cal) push(integ, 0, 1, "R8 integral");
    if (hit && !cal) begin
      fs = (pk >= pre) ? pk - pre : 0;
      fe = (pk + post > n - 1) ? n - 1 : pk + post;
      for (int i = fs; i <= fe; i++) push(smp[i], 0, i == n - 1, "R6 fine sample");
      g = r8 ? 8 : 4; acc = 0; cnt = 0;
      for (int i = fe + 1; i < n; i++) begin
        acc += smp[i]; cnt++;
        if (cnt == g || i == n - 1) begin
          push(acc, 0, i == n - 1, r8 ? "R7 tail 8:1" : "R7 tail 4:1");
          acc = 0; cnt = 0;
        end
      end
    end
    @(negedge clk);
    cfg_nsig = nsig[3:0]; cfg_dead = dead[9:0]; cfg_pre = pre[5:0];
    cfg_post = post[5:0]; cfg_ratio8 = r8; cfg_calib = cal;
    for (int i = 0; i < ndrive; i++) begin
      in_valid = 1; in_first = (i == 0); in_last = (i == ndrive - 1);
      in_sample = smp[i][9:0];
      @(negedge clk);
    end
    in_valid = 0; in_first = 0; in_last = 0;
    for (int k = 0; k < 400 && expq.size() != 0; k++) @(negedge clk);
    if (expq.size() != 0) begin
      fails += expq.size();
      $display("FAIL R9 record incomplete: actual %0d words missing, expected 0", expq.size());
      expq.delete(); tagq.delete();
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1 out_valid actual %b expected 0", out_valid);
    end
    rst_n = 1;
    repeat (2) @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R1 idle out_valid actual %b expected 0", out_valid);
    end
    // R2 threshold edge: alternating 100/101 baseline, small bump (exactly at limit)
    for (int i = 0; i < 32; i++) smp[i] = 100 + (i % 2);
    smp[20] = 102;
    run_window(32, 4, 0, 2, 2, 0, 0);   // R5 ripple with zero dead band -> pile-up
    smp[20] = 103;
    run_window(32, 4, 1, 2, 2, 0, 0);   // just above limit, dead band hides ripple
    // R6 R7 single pulse, 4:1 and 8:1 tails
    make_wave(48, 50, 1, 30, 200, 999, 0);
    run_window(48, 4, 3, 2, 3, 0, 0);
    run_window(48, 4, 3, 2, 3, 1, 0);
    // R8 calibration integral
    run_window(48, 4, 3, 2, 3, 0, 1);
    // R5 double pulse
    make_wave(60, 80, 1, 25, 150, 45, 120);
    run_window(60, 3, 3, 4, 4, 1, 0);
    // R9 fine region ends at window end, no tail
    make_wave(64, 40, 0, 61, 300, 999, 0);
    run_window(64, 2, 0, 40, 20, 0, 0);
    // R6 pre clipped at index 0, R7 partial final group
    make_wave(41, 40, 1, 18, 90, 999, 0);
    run_window(41, 2, 3, 30, 2, 1, 0);
    // R10 samples past the 64th dropped
    make_wave(70, 60, 1, 40, 100, 66, 400);
    run_window(70, 4, 3, 3, 3, 0, 0);
    // R3 flat baseline, no pulse
    make_wave(20, 70, 0, 999, 0, 999, 0);
    run_window(20, 1, 0, 1, 1, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule